// File: doc/BRIEF.md
# Banked Control Register File With Write Masks

This block holds the system-control registers of a multithreaded core. A register is reached by a 5-bit register number and a 3-bit select, which together form a flat index `number*8 + select`. Each register has a fixed bank kind. A core-wide register has one copy. A per-thread register has one copy for each thread context, chosen directly by the thread id. A per-virtual-processor register has one copy for each virtual processor. For those, the copy is chosen by the virtual-processor field in bits [VP_W-1:0] of the binding register that belongs to the accessing thread.

Writes come in two kinds. A guarded write (`wr_raw`=0) changes only the bits set in that register's fixed write mask and keeps every other bit. A raw write (`wr_raw`=1) is meant for updates from hardware: it stores the whole word and ignores the mask. Reads are combinational. A write lands on the next rising clock edge. A synchronous reset first clears every copy and then loads the identification, configuration and binding values.

The mapped registers are given as name (number.select, bank, mask, reset value):
- watch (19.0, core, 7FFF0FFF, 0)
- ll-addr (17.0, thread, 0, 0)
- cfg3 (16.3, core, 0, 0)
- cfg1 (16.1, core, 0, CFG1_VALUE)
- cfg0 (16.0, core, 7FFF0007, 80000000|CFG0_VALUE)
- exc-base (15.1, vproc, 3FFFF000, 80000000)
- proc-id (15.0, core, 0, ID_VALUE)
- cause (13.0, core, 08C00300, 0)
- shadow-ctl (12.2, core, 0000F3C0, 0)
- int-ctl (12.1, core, 000003E0, 0)
- status (12.0, thread, FF78FF17, 00400004)
- bad-vaddr (8.0, core, 0, 0)
- page-grain (5.1, core, 10000000, 0)
- page-mask (5.0, core, 1FFFF800, 0)
- context (4.0, core, FF800000, 0)
- entry-lo1 (3.0, core, 3FFFFFFF, 0)
- halt (2.4, thread, FFFFFFFF, 0)
- bind (2.2, thread, FFFFFFFF, tid<<21)
- entry-lo0 (2.0, core, 3FFFFFFF, 0)
- vp-ctl (1.1, vproc, FFFFFFFF, 0)
- random (1.0, core, 0, 63)
- index (0.0, core, 7FFFFFFF, 0)

Top module: `ctlrf_top`

## Requirements
- R1: The register is selected by the flat index number*8+select. Neighbouring selects of one number (for example 12.0 and 12.1) are separate registers. An index that is not in the map reads 0, and a write to it changes nothing.
- R2: A guarded write stores (wr_data AND mask) OR (old AND NOT mask) for the addressed copy.
- R3: Registers whose mask is zero (random, proc-id, cfg1, cfg3, bad-vaddr, ll-addr) keep their value across any guarded write.
- R4: Per-thread registers (status, bind, halt, ll-addr) keep a separate copy for each thread id.
- R5: A raw write stores the full wr_data, whatever the mask is.
- R6: Per-virtual-processor registers (vp-ctl, exc-base) use the copy named by bits [VP_W-1:0] of the accessing thread's bind register. Threads bound to the same value share that copy.
- R7: After reset, the registers read: random 63, every status copy 0x00400004, every exc-base copy 0x80000000, cfg0 0x80000000|CFG0_VALUE, proc-id ID_VALUE, cfg1 CFG1_VALUE, and every other register 0.
- R8: After reset, the bind copy of thread t holds t in bits [28:21] and zero in all other bits, so every thread starts bound to virtual processor 0.
- R9: rd_data follows the address and tid inputs combinationally. A write is not visible before the rising edge that captures it, and it is visible straight after that edge.
- R10: Core-wide registers have one copy that every thread id reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tid | input | TID_W | Thread id of the access |
| reg_num | input | 5 | Register number |
| reg_sel | input | 3 | Select within the register number |
| wr_en | input | 1 | Write the addressed copy on this edge |
| wr_raw | input | 1 | 1: raw write that ignores the mask; 0: guarded write |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Value of the addressed copy, or 0 when unmapped |

## Verification
The bench writes all-ones and patterned words to registers with narrow masks and with zero masks. A design that ignored the mask, or inverted it, would show flipped read-only bits. The bench rebinds one thread to the second virtual processor and compares what threads see in the per-virtual-processor registers. A design that indexed those registers by thread id, or read the wrong binding copy, would leak values between threads. The bench also samples a write in the half cycle before its edge and again after it, which catches a write path that bypasses the register. It probes unmapped indices and adjacent selects, which catches a decoder that drops the select bits.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
  localparam int DW          = 32;
  localparam int SLOT_W      = 5;
  localparam int NSLOT       = 23;
  localparam int BIND_TC_LSB = 21;

  typedef enum logic [1:0] {BK_CORE, BK_VPROC, BK_THREAD} bank_e;

  typedef enum logic [SLOT_W-1:0] {
    S_NONE, S_INDEX, S_RAND, S_VPCTL, S_ELO0, S_BIND, S_HALT, S_ELO1,
    S_CTX, S_PGMASK, S_PGGRAIN, S_BADVA, S_STAT, S_INTCTL, S_SHADOW,
    S_CAUSE, S_PROCID, S_EXBASE, S_CFG0, S_CFG1, S_CFG3, S_LLADDR, S_WATCH
  } slot_e;

  // flat index = number*8 + select
  function automatic slot_e slot_of(input logic [7:0] flat);
    case (flat)
      8'd0:    slot_of = S_INDEX;
      8'd8:    slot_of = S_RAND;
      8'd9:    slot_of = S_VPCTL;
      8'd16:   slot_of = S_ELO0;
      8'd18:   slot_of = S_BIND;
      8'd20:   slot_of = S_HALT;
      8'd24:   slot_of = S_ELO1;
      8'd32:   slot_of = S_CTX;
      8'd40:   slot_of = S_PGMASK;
      8'd41:   slot_of = S_PGGRAIN;
      8'd64:   slot_of = S_BADVA;
      8'd96:   slot_of = S_STAT;
      8'd97:   slot_of = S_INTCTL;
      8'd98:   slot_of = S_SHADOW;
      8'd104:  slot_of = S_CAUSE;
      8'd120:  slot_of = S_PROCID;
      8'd121:  slot_of = S_EXBASE;
      8'd128:  slot_of = S_CFG0;
      8'd129:  slot_of = S_CFG1;
      8'd131:  slot_of = S_CFG3;
      8'd136:  slot_of = S_LLADDR;
      8'd152:  slot_of = S_WATCH;
      default: slot_of = S_NONE;
    endcase
  endfunction

  function automatic bank_e bank_of(input slot_e s);
    case (s)
      S_STAT, S_BIND, S_HALT, S_LLADDR: bank_of = BK_THREAD;
      S_VPCTL, S_EXBASE:                bank_of = BK_VPROC;
      default:                          bank_of = BK_CORE;
    endcase
  endfunction

  function automatic logic [DW-1:0] mask_of(input slot_e s);
    case (s)
      S_INDEX:          mask_of = 32'h7FFF_FFFF;
      S_ELO0, S_ELO1:   mask_of = 32'h3FFF_FFFF;
      S_CTX:            mask_of = 32'hFF80_0000;
      S_PGMASK:         mask_of = 32'h1FFF_F800;
      S_PGGRAIN:        mask_of = 32'h1000_0000;
      S_STAT:           mask_of = 32'hFF78_FF17;
      S_INTCTL:         mask_of = 32'h0000_03E0;
      S_SHADOW:         mask_of = 32'h0000_F3C0;
      S_CAUSE:          mask_of = 32'h08C0_0300;
      S_EXBASE:         mask_of = 32'h3FFF_F000;
      S_CFG0:           mask_of = 32'h7FFF_0007;
      S_WATCH:          mask_of = 32'h7FFF_0FFF;
      S_RAND, S_BADVA, S_PROCID, S_CFG1, S_CFG3, S_LLADDR, S_NONE:
                        mask_of = '0;
      default:          mask_of = '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_of(input slot_e s, input int cp,
                                             input logic [DW-1:0] id_v,
                                             input logic [DW-1:0] cfg0_v,
                                             input logic [DW-1:0] cfg1_v);
    case (s)
      S_RAND:   reset_of = 32'd63;
      S_STAT:   reset_of = 32'h0040_0004;
      S_EXBASE: reset_of = 32'h8000_0000;
      S_CFG0:   reset_of = 32'h8000_0000 | cfg0_v;
      S_PROCID: reset_of = id_v;
      S_CFG1:   reset_of = cfg1_v;
      S_BIND:   reset_of = DW'(cp) << BIND_TC_LSB;
      default:  reset_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/ctlrf_decode.sv
module ctlrf_decode
  import ctlrf_pkg::*;
(
  input  logic [4:0]    reg_num,
  input  logic [2:0]    reg_sel,
  output slot_e         slot,
  output bank_e         bank,
  output logic [DW-1:0] wmask
);
  always_comb begin
    slot  = slot_of({reg_num, reg_sel});
    bank  = bank_of(slot);
    wmask = mask_of(slot);
  end
endmodule

// File: rtl/ctlrf_bank_sel.sv
module ctlrf_bank_sel
  import ctlrf_pkg::*;
#(
  parameter int NUM_TC = 4,
  parameter int NUM_VP = 2,
  parameter int TID_W  = 2,
  parameter int VP_W   = 1,
  parameter int CPY_W  = 2
) (
  input  bank_e              bank,
  input  logic [TID_W-1:0]   tid,
  input  logic [VP_W-1:0]    bound_vp,
  output logic [CPY_W-1:0]   copy,
  output logic               hit
);
  always_comb begin
    hit  = 1'b1;
    copy = '0;
    case (bank)
      BK_CORE:   copy = '0;
      BK_THREAD: begin
        copy = CPY_W'(tid);
        hit  = (32'(tid) < NUM_TC);
      end
      BK_VPROC:  begin
        copy = CPY_W'(bound_vp);
        hit  = (32'(bound_vp) < NUM_VP);
      end
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctlrf_merge.sv
module ctlrf_merge
  import ctlrf_pkg::*;
(
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] nxt,
  input  logic [DW-1:0] wmask,
  input  logic          raw,
  output logic [DW-1:0] merged
);
  always_comb begin
    if (raw) merged = nxt;
    else     merged = (nxt & wmask) | (cur & ~wmask);
  end
endmodule

// File: rtl/ctlrf_top.sv
module ctlrf_top
  import ctlrf_pkg::*;
#(
  parameter int          NUM_TC     = 4,
  parameter int          NUM_VP     = 2,
  parameter logic [31:0] ID_VALUE   = 32'h00A1_0203,
  parameter logic [31:0] CFG0_VALUE = 32'h0000_0483,
  parameter logic [31:0] CFG1_VALUE = 32'h1E19_0C8A,
  localparam int TID_W = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TID_W-1:0] tid,
  input  logic [4:0]       reg_num,
  input  logic [2:0]       reg_sel,
  input  logic             wr_en,
  input  logic             wr_raw,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data
);
  localparam int VP_W  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1;
  localparam int NCOPY = (NUM_TC > NUM_VP) ? NUM_TC : NUM_VP;
  localparam int CPY_W = (NCOPY > 1) ? $clog2(NCOPY) : 1;

  logic [DW-1:0] mem_q [NSLOT][2**CPY_W];

  slot_e            slot;
  bank_e            bank;
  logic [DW-1:0]    wmask;
  logic [CPY_W-1:0] copy;
  logic [CPY_W-1:0] tid_cp;
  logic             hit, access_ok;
  logic [DW-1:0]    cur_val, merged;

  ctlrf_decode u_dec (
    .reg_num (reg_num),
    .reg_sel (reg_sel),
    .slot    (slot),
    .bank    (bank),
    .wmask   (wmask)
  );

  assign tid_cp = CPY_W'(tid);

  ctlrf_bank_sel #(
    .NUM_TC (NUM_TC), .NUM_VP (NUM_VP), .TID_W (TID_W),
    .VP_W   (VP_W),   .CPY_W  (CPY_W)
  ) u_bank (
    .bank     (bank),
    .tid      (tid),
    .bound_vp (mem_q[S_BIND][tid_cp][VP_W-1:0]),
    .copy     (copy),
    .hit      (hit)
  );

  assign access_ok = hit && (slot != S_NONE);
  assign cur_val   = mem_q[slot][copy];
  assign rd_data   = access_ok ? cur_val : '0;

  ctlrf_merge u_merge (
    .cur    (cur_val),
    .nxt    (wr_data),
    .wmask  (wmask),
    .raw    (wr_raw),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) begin
        for (int c = 0; c < 2**CPY_W; c++) begin
          mem_q[s][c] <= reset_of(slot_e'(SLOT_W'(s)), c, ID_VALUE, CFG0_VALUE, CFG1_VALUE);
        end
      end
    end else if (wr_en && access_ok) begin
      mem_q[slot][copy] <= merged;
    end
  end

  // R2: masked bits take the written value
  p_guard_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_raw && access_ok) |=>
      (!$stable({tid, reg_num, reg_sel}) ||
       ((rd_data & $past(wmask)) == ($past(wr_data) & $past(wmask)))));

  // R3: bits outside the mask are kept by a guarded write
  p_keep_ro_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_raw) |=>
      (!$stable({tid, reg_num, reg_sel}) ||
       (((rd_data ^ $past(rd_data)) & ~$past(wmask)) == '0)));

  // R5: a raw write lands whole
  p_raw_full_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_raw && access_ok) |=>
      (!$stable({tid, reg_num, reg_sel}) || (rd_data == $past(wr_data))));

  // R7: random register right after reset
  p_rand_reset_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && slot == S_RAND) |-> (rd_data == 32'd63));

  // R8: binding register right after reset
  p_bind_reset_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && slot == S_BIND) |-> (rd_data == (DW'(tid) << BIND_TC_LSB)));
endmodule

// File: tb/ctlrf_top_bench.sv
module ctlrf_top_bench;
  localparam logic [31:0] IDV  = 32'h00A1_0203;
  localparam logic [31:0] CF0V = 32'h0000_0483;
  localparam logic [31:0] CF1V = 32'h1E19_0C8A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  tid = '0;
  logic [4:0]  reg_num = '0;
  logic [2:0]  reg_sel = '0;
  logic        wr_en = 1'b0;
  logic        wr_raw = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ctlrf_top #(.NUM_TC(4), .NUM_VP(2), .ID_VALUE(IDV), .CFG0_VALUE(CF0V),
              .CFG1_VALUE(CF1V)) u_ctlrf_top (
    .clk(clk), .rst(rst), .tid(tid), .reg_num(reg_num), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_raw(wr_raw), .wr_data(wr_data), .rd_data(rd_data));

  function automatic logic [31:0] fmerge(input logic [31:0] cur, nw, m);
    return (nw & m) | (cur & ~m);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, input logic [1:0] t,
                    output logic [31:0] v);
    @(negedge clk);
    reg_num = n; reg_sel = s; tid = t; wr_en = 1'b0;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [1:0] t,
                    input logic [31:0] d, input logic raw);
    @(negedge clk);
    reg_num = n; reg_sel = s; tid = t; wr_data = d; wr_raw = raw; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_raw = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1, 0, 0, v);  check("R7 random", v, 32'd63);
    rd(15, 0, 2, v); check("R7 proc-id", v, IDV);
    rd(16, 0, 0, v); check("R7 cfg0", v, 32'h8000_0000 | CF0V);
    rd(16, 1, 0, v); check("R7 cfg1", v, CF1V);
    rd(15, 1, 3, v); check("R7 exc-base", v, 32'h8000_0000);
    rd(0, 0, 0, v);  check("R7 index zero", v, 32'h0);
    for (int t = 0; t < 4; t++) begin
      rd(12, 0, 2'(t), v); check("R7 status", v, 32'h0040_0004);
      rd(2, 2, 2'(t), v);  check("R8 bind", v, 32'(t) << 21);
    end
  endtask

  task automatic t_timing;
    @(negedge clk);
    reg_num = 2; reg_sel = 4; tid = 1; wr_data = 32'h77; wr_raw = 1'b0; wr_en = 1'b1;
    #1 check("R9 before edge", rd_data, 32'h0);
    @(posedge clk);
    #1 check("R9 after edge", rd_data, 32'h77);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(1, 0, 0, 32'hFFFF_FFFF, 1'b0);  rd(1, 0, 0, v);  check("R3 random", v, 32'd63);
    wr(15, 0, 0, 32'h0, 1'b0);         rd(15, 0, 0, v); check("R3 proc-id", v, IDV);
    wr(16, 1, 1, 32'h0, 1'b0);         rd(16, 1, 1, v); check("R3 cfg1", v, CF1V);
    wr(16, 3, 0, 32'hFFFF_FFFF, 1'b0); rd(16, 3, 0, v); check("R3 cfg3", v, 32'h0);
    wr(8, 0, 0, 32'hFFFF_FFFF, 1'b0);  rd(8, 0, 0, v);  check("R3 bad-vaddr", v, 32'h0);
    wr(17, 0, 3, 32'hFFFF_FFFF, 1'b0); rd(17, 0, 3, v); check("R3 ll-addr", v, 32'h0);
  endtask

  task automatic t_guard;
    logic [31:0] v;
    wr(0, 0, 0, 32'hFFFF_FFFF, 1'b0); rd(0, 0, 0, v); check("R2 index", v, 32'h7FFF_FFFF);
    wr(13, 0, 0, 32'hFFFF_FFFF, 1'b0); rd(13, 0, 0, v); check("R2 cause ones", v, 32'h08C0_0300);
    wr(13, 0, 0, 32'h1234_5678, 1'b0); rd(13, 0, 0, v);
    check("R2 cause pattern", v, fmerge(32'h08C0_0300, 32'h1234_5678, 32'h08C0_0300));
    wr(12, 0, 1, 32'hFFFF_FFFF, 1'b0); rd(12, 0, 1, v); check("R2 status ones", v, 32'hFF78_FF17);
    wr(16, 0, 0, 32'h0, 1'b0); rd(16, 0, 0, v);
    check("R2 cfg0 clear", v, fmerge(32'h8000_0000 | CF0V, 32'h0, 32'h7FFF_0007));
    wr(5, 0, 0, 32'hAAAA_AAAA, 1'b0); rd(5, 0, 0, v);
    check("R2 page-mask", v, 32'hAAAA_AAAA & 32'h1FFF_F800);
  endtask

  task automatic t_raw;
    logic [31:0] v;
    wr(15, 0, 0, 32'h1234_5678, 1'b1); rd(15, 0, 0, v); check("R5 proc-id raw", v, 32'h1234_5678);
    wr(17, 0, 2, 32'hDEAD_BEEF, 1'b1); rd(17, 0, 2, v); check("R5 ll-addr raw", v, 32'hDEAD_BEEF);
    wr(0, 0, 0, 32'hFFFF_FFFF, 1'b1);  rd(0, 0, 0, v);  check("R5 index raw", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_thread;
    logic [31:0] v;
    wr(2, 4, 2, 32'hA5, 1'b0);
    rd(2, 4, 2, v); check("R4 halt tid2", v, 32'hA5);
    rd(2, 4, 0, v); check("R4 halt tid0", v, 32'h0);
    rd(2, 4, 1, v); check("R4 halt tid1", v, 32'h77);
    rd(17, 0, 0, v); check("R4 ll-addr tid0", v, 32'h0);
    rd(12, 0, 0, v); check("R4 status tid0", v, 32'h0040_0004);
  endtask

  task automatic t_shared;
    logic [31:0] v;
    wr(2, 0, 3, 32'h0BAD_F00D, 1'b0);
    rd(2, 0, 0, v); check("R10 entry-lo0 from tid0", v, 32'h0BAD_F00D);
    rd(13, 0, 2, v);
    check("R10 cause from tid2", v, fmerge(32'h08C0_0300, 32'h1234_5678, 32'h08C0_0300));
  endtask

  task automatic t_vp;
    logic [31:0] v;
    wr(15, 1, 0, 32'hFFFF_FFFF, 1'b0);
    rd(15, 1, 0, v); check("R6 exc-base tid0", v, 32'hBFFF_F000);
    rd(15, 1, 1, v); check("R6 exc-base shared vp0", v, 32'hBFFF_F000);
    wr(2, 2, 2, (32'd2 << 21) | 32'd1, 1'b0);
    rd(2, 2, 2, v);  check("R6 bind tid2", v, (32'd2 << 21) | 32'd1);
    rd(15, 1, 2, v); check("R6 exc-base vp1", v, 32'h8000_0000);
    wr(1, 1, 2, 32'h55, 1'b0);
    rd(1, 1, 2, v); check("R6 vp-ctl vp1", v, 32'h55);
    rd(1, 1, 3, v); check("R6 vp-ctl vp0 tid3", v, 32'h0);
    rd(1, 1, 0, v); check("R6 vp-ctl vp0 tid0", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(7, 0, 0, 32'hFFFF_FFFF, 1'b1); rd(7, 0, 0, v); check("R1 unmapped 7.0", v, 32'h0);
    wr(16, 2, 0, 32'h1111_1111, 1'b1); rd(16, 2, 0, v); check("R1 unmapped 16.2", v, 32'h0);
    rd(16, 3, 0, v); check("R1 neighbour 16.3", v, 32'h0);
    wr(12, 1, 0, 32'hFFFF_FFFF, 1'b0);
    rd(12, 1, 0, v); check("R1 int-ctl 12.1", v, 32'h0000_03E0);
    rd(12, 0, 0, v); check("R1 status 12.0 intact", v, 32'h0040_0004);
    rd(12, 2, 0, v); check("R1 shadow 12.2 intact", v, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timing();
    t_readonly();
    t_guard();
    t_raw();
    t_thread();
    t_shared();
    t_vp();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule